// File: doc/BRIEF.md
# I2C Slave Address Recognition Unit

This unit sits on the SCL and SDA lines of a two-wire bus and decides whether the local slave is being addressed. It synchronizes both lines and finds bus conditions: a falling SDA edge while SCL is high opens a transfer, and a rising SDA edge while SCL is high closes it. It collects the address byte or bytes that follow and compares them with a programmed address. Both 7-bit and 10-bit addressing are supported, and two reserved addresses are also recognised when enabled. On a match it pulls SDA low during the ninth clock.

Software sees the result through a status word on a plain read port. The word holds a live selected bit, the origin of the match (own address or reserved address), the kind of reserved address, the transfer direction, a flag that marks the end of a selected transfer together with its kind, and a flag for a refused byte. The two event flags clear when software reads the word. A flag raised in the same cycle as the read wins over the clear. Moving data bytes, stretching the clock and generating the clock are handled elsewhere.

Top module: `i2c_slave_addr_unit`

## Requirements
- R1: With cfg_ten_bit=0, a first byte after a bus opening whose upper seven bits equal cfg_addr[6:0] is acknowledged: SDA is held low for the whole high phase of the ninth clock. stat_data bit0 (selected) becomes 1 and bit3 (direction) takes the byte's bit0, where 1 means read.
- R2: With cfg_ten_bit=1, a first byte equal to {11110, cfg_addr[9:8], 0} is acknowledged without selecting the slave. A second byte equal to cfg_addr[7:0] is then acknowledged, sets bit0 and clears bit3. Any other second byte is not acknowledged and leaves bit0 at 0.
- R3: After a full 10-bit match, a repeated opening followed by {11110, cfg_addr[9:8], 1} is acknowledged at once, with bit0=1 and bit3=1. The same byte is refused once a closing has occurred since that match.
- R4: With cfg_gc_en=1, byte 0x00 is acknowledged with bit1=1, bit2=0 and bit3=0, and byte 0x01 is acknowledged with bit1=1, bit2=1 and bit3=1. With cfg_gc_en=0 neither byte is acknowledged.
- R5: A match on the programmed address leaves bit1 and bit2 at 0.
- R6: A first byte that matches nothing leaves SDA released in the ninth clock. Every later byte is also refused until the next bus opening.
- R7: A closing or a repeated opening while bit0=1 sets bit4. Bit5 becomes 0 for a closing and 1 for a repeated opening, and bit0 clears. While bit0=0 these conditions leave bit4 unchanged.
- R8: In a selected transfer, SDA high during the ninth clock of a data byte sets bit6. SDA low there leaves bit6 unchanged.
- R9: While stat_rd is high, stat_data shows the status of that cycle. Bits 4 and 6 clear at the following clock edge, while bits 0 to 3 and bit5 keep their values. Bit7 always reads 0.
- R10: A bit4 or bit6 event in the same cycle as a read leaves that bit set after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Raw bus clock line |
| sda_in | input | 1 | Raw bus data line |
| cfg_ten_bit | input | 1 | 1 selects 10-bit addressing |
| cfg_gc_en | input | 1 | 1 enables the reserved 0x00 and 0x01 addresses |
| cfg_addr | input | 10 | Programmed slave address; bits 6:0 are used in 7-bit mode |
| stat_rd | input | 1 | Status read strobe; clears the event flags |
| sda_oe | output | 1 | 1 pulls SDA low |
| stat_data | output | 8 | Status word |

## Verification
The bench builds the unit with SYNC_STAGES=3, one stage more than the default. This lengthens the delay from every line change to its effect and shows that the acknowledge still lands inside the ninth clock with margin. The programmed 10-bit address has both upper bits different, so a header byte with swapped bits would be refused. The bench holds the read strobe high across a closing so that the event meets a read in the same cycle. A behavioural model predicts the acknowledge of every byte and the status word after every bus action.

// File: rtl/i2c_addr_pkg.sv
package i2c_addr_pkg;

    localparam int BYTE_W  = 8;
    localparam int ADDR_W  = 10;
    localparam int STAT_W  = 8;
    localparam int A7_W    = BYTE_W - 1;
    localparam int BCNT_W  = $clog2(BYTE_W + 2);

    // bit counter values: eight bits shifted, ninth clock seen
    localparam logic [BCNT_W-1:0] CNT_ACK = BCNT_W'(BYTE_W);
    localparam logic [BCNT_W-1:0] CNT_END = BCNT_W'(BYTE_W + 1);

    localparam logic [4:0]        TEN_PREFIX = 5'b11110;
    localparam logic [BYTE_W-1:0] GC_CODE    = 8'h00;
    localparam logic [BYTE_W-1:0] SB_CODE    = 8'h01;

    // status word bit positions
    localparam int ST_SEL = 0;
    localparam int ST_ALT = 1;
    localparam int ST_SB  = 2;
    localparam int ST_RD  = 3;
    localparam int ST_SR  = 4;
    localparam int ST_SRK = 5;
    localparam int ST_NAK = 6;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR1,
        PH_ADDR2,
        PH_DATA,
        PH_SKIP
    } phase_e;

    typedef struct packed {
        logic sr_set;
        logic sr_restart;
        logic nak_set;
        logic hit;
        logic hit_alt;
        logic hit_sb;
        logic hit_rd;
    } evt_t;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '1;
        else        sh_q <= sh_d;
    end

    assign dout = sh_q[STAGES-1];
endmodule

// File: rtl/i2c_bus_cond.sv
module i2c_bus_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt
);
    typedef struct packed {
        logic scl;
        logic sda;
    } prev_t;

    prev_t d, q;

    always_comb begin
        d.scl     = scl_s;
        d.sda     = sda_s;
        scl_rise  = scl_s & ~q.scl;
        scl_fall  = ~scl_s & q.scl;
        start_evt = scl_s & q.scl & q.sda & ~sda_s;
        stop_evt  = scl_s & q.scl & ~q.sda & sda_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '1;
        else        q <= d;
    end
endmodule

// File: rtl/i2c_addr_fsm.sv
module i2c_addr_fsm
    import i2c_addr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_evt,
    input  logic              stop_evt,
    input  logic              cfg_ten_bit,
    input  logic              cfg_gc_en,
    input  logic [ADDR_W-1:0] cfg_addr,
    output logic              sda_oe,
    output logic              sel,
    output evt_t              evt
);
    typedef struct packed {
        phase_e            ph;
        phase_e            after;
        logic [BCNT_W-1:0] cnt;
        logic [BYTE_W-1:0] sh;
        logic              oe;
        logic              sel;
        logic              armed;
    } fsm_t;

    fsm_t d, q;

    logic hit7, hdr_match, hdr_wr, hdr_rd, gc_hit, sb_hit, low_hit;

    always_comb begin
        hit7      = !cfg_ten_bit && (q.sh[BYTE_W-1:1] == cfg_addr[A7_W-1:0]);
        hdr_match = cfg_ten_bit && (q.sh[BYTE_W-1:BYTE_W-5] == TEN_PREFIX)
                    && (q.sh[2:1] == cfg_addr[ADDR_W-1:BYTE_W]);
        hdr_wr    = hdr_match && !q.sh[0];
        hdr_rd    = hdr_match && q.sh[0] && q.armed;
        gc_hit    = cfg_gc_en && (q.sh == GC_CODE);
        sb_hit    = cfg_gc_en && (q.sh == SB_CODE);
        low_hit   = (q.sh == cfg_addr[BYTE_W-1:0]);
    end

    always_comb begin
        d   = q;
        evt = '0;
        if (stop_evt) begin
            if (q.sel) begin
                evt.sr_set     = 1'b1;
                evt.sr_restart = 1'b0;
            end
            d.ph    = PH_IDLE;
            d.sel   = 1'b0;
            d.armed = 1'b0;
            d.oe    = 1'b0;
            d.cnt   = '0;
        end else if (start_evt) begin
            if (q.sel) begin
                evt.sr_set     = 1'b1;
                evt.sr_restart = 1'b1;
            end
            d.ph  = PH_ADDR1;
            d.sel = 1'b0;
            d.oe  = 1'b0;
            d.cnt = '0;
        end else if (q.ph == PH_ADDR1 || q.ph == PH_ADDR2 || q.ph == PH_DATA) begin
            if (scl_rise) begin
                if (q.cnt < CNT_ACK) begin
                    d.sh  = {q.sh[BYTE_W-2:0], sda_s};
                    d.cnt = q.cnt + 1'b1;
                end else if (q.cnt == CNT_ACK) begin
                    d.cnt = CNT_END;
                    if (q.ph == PH_DATA && sda_s && q.sel) evt.nak_set = 1'b1;
                end
            end else if (scl_fall) begin
                if (q.cnt == CNT_ACK) begin
                    d.after = PH_DATA;
                    if (q.ph == PH_ADDR1) begin
                        if (hit7) begin
                            d.oe = 1'b1; d.sel = 1'b1;
                            evt.hit = 1'b1; evt.hit_rd = q.sh[0];
                        end else if (hdr_wr) begin
                            d.oe = 1'b1; d.armed = 1'b0;
                            d.after = PH_ADDR2;
                        end else if (hdr_rd) begin
                            d.oe = 1'b1; d.sel = 1'b1;
                            evt.hit = 1'b1; evt.hit_rd = 1'b1;
                        end else if (gc_hit || sb_hit) begin
                            d.oe = 1'b1; d.sel = 1'b1;
                            evt.hit = 1'b1; evt.hit_alt = 1'b1;
                            evt.hit_sb = sb_hit; evt.hit_rd = q.sh[0];
                        end else begin
                            d.armed = 1'b0;
                            d.after = PH_SKIP;
                        end
                    end else if (q.ph == PH_ADDR2) begin
                        if (low_hit) begin
                            d.oe = 1'b1; d.sel = 1'b1; d.armed = 1'b1;
                            evt.hit = 1'b1;
                        end else begin
                            d.armed = 1'b0;
                            d.after = PH_SKIP;
                        end
                    end
                end else if (q.cnt == CNT_END) begin
                    d.oe  = 1'b0;
                    d.cnt = '0;
                    d.ph  = q.after;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.ph    <= PH_IDLE;
            q.after <= PH_IDLE;
        end else begin
            q <= d;
        end
    end

    assign sda_oe = q.oe;
    assign sel    = q.sel;
endmodule

// File: rtl/i2c_evt_status.sv
module i2c_evt_status
    import i2c_addr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  evt_t              evt,
    input  logic              sel,
    input  logic              stat_rd,
    output logic [STAT_W-1:0] stat_data
);
    typedef struct packed {
        logic alt;
        logic sb;
        logic rdir;
        logic sr;
        logic srk;
        logic nak;
    } st_t;

    st_t d, q;

    always_comb begin
        d = q;
        if (stat_rd) begin
            d.sr  = 1'b0;
            d.nak = 1'b0;
        end
        if (evt.hit) begin
            d.alt  = evt.hit_alt;
            d.sb   = evt.hit_sb;
            d.rdir = evt.hit_rd;
        end
        if (evt.sr_set) begin
            d.sr  = 1'b1;
            d.srk = evt.sr_restart;
        end
        if (evt.nak_set) d.nak = 1'b1;

        stat_data         = '0;
        stat_data[ST_SEL] = sel;
        stat_data[ST_ALT] = q.alt;
        stat_data[ST_SB]  = q.sb;
        stat_data[ST_RD]  = q.rdir;
        stat_data[ST_SR]  = q.sr;
        stat_data[ST_SRK] = q.srk;
        stat_data[ST_NAK] = q.nak;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/i2c_slave_addr_unit.sv
module i2c_slave_addr_unit
    import i2c_addr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    input  logic              cfg_ten_bit,
    input  logic              cfg_gc_en,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic              stat_rd,
    output logic              sda_oe,
    output logic [STAT_W-1:0] stat_data
);
    localparam int N_LINES = 2;

    logic [N_LINES-1:0] raw, syncd;
    logic scl_s, sda_s;
    logic scl_rise, scl_fall, start_evt, stop_evt;
    logic sel;
    evt_t evt;
    logic ev_sr_set, ev_nak_set;

    assign raw = {scl_in, sda_in};

    for (genvar g = 0; g < N_LINES; g++) begin : g_sync
        i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (raw[g]),
            .dout (syncd[g])
        );
    end

    assign scl_s = syncd[1];
    assign sda_s = syncd[0];

    i2c_bus_cond u_cond (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_s    (scl_s),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_evt(start_evt),
        .stop_evt (stop_evt)
    );

    i2c_addr_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .sda_s      (sda_s),
        .scl_rise   (scl_rise),
        .scl_fall   (scl_fall),
        .start_evt  (start_evt),
        .stop_evt   (stop_evt),
        .cfg_ten_bit(cfg_ten_bit),
        .cfg_gc_en  (cfg_gc_en),
        .cfg_addr   (cfg_addr),
        .sda_oe     (sda_oe),
        .sel        (sel),
        .evt        (evt)
    );

    i2c_evt_status u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt      (evt),
        .sel      (sel),
        .stat_rd  (stat_rd),
        .stat_data(stat_data)
    );

    assign ev_sr_set  = evt.sr_set;
    assign ev_nak_set = evt.nak_set;
endmodule

// File: rtl/i2c_addr_chk.sv
module i2c_addr_chk
    import i2c_addr_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              scl_s,
    input logic              start_evt,
    input logic              stop_evt,
    input logic              sda_oe,
    input logic              stat_rd,
    input logic [STAT_W-1:0] stat_data,
    input logic              sr_set,
    input logic              nak_set
);
    AST_OE_HELD_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_s && $past(scl_s) && !$past(start_evt) && !$past(stop_evt)) |-> $stable(sda_oe)); // R1
    AST_READ_CLEARS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !sr_set && !nak_set) |=> (!stat_data[ST_SR] && !stat_data[ST_NAK])); // R9
    AST_EVENT_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && sr_set) |=> stat_data[ST_SR]); // R10
    AST_SR_NEEDS_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_data[ST_SR]) |-> $past(stat_data[ST_SEL])); // R7
    AST_NAK_NEEDS_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_data[ST_NAK]) |-> $past(stat_data[ST_SEL])); // R8
    AST_CLOSE_DESELECTS: assert property (@(posedge clk) disable iff (!rst_n)
        stop_evt |=> (!sda_oe && !stat_data[ST_SEL])); // R7
    AST_TOP_BIT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_data[STAT_W-1]); // R9
endmodule

bind i2c_slave_addr_unit i2c_addr_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_s    (scl_s),
    .start_evt(start_evt),
    .stop_evt (stop_evt),
    .sda_oe   (sda_oe),
    .stat_rd  (stat_rd),
    .stat_data(stat_data),
    .sr_set   (ev_sr_set),
    .nak_set  (ev_nak_set)
);

// File: tb/test_i2c_slave_addr_unit.sv
module test_i2c_slave_addr_unit;
    import i2c_addr_pkg::*;

    localparam int HALF = 10;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_n;
    logic scl_drv, sda_drv, sda_line;
    logic cfg_ten_bit, cfg_gc_en, stat_rd;
    logic [ADDR_W-1:0] cfg_addr;
    logic sda_oe;
    logic [STAT_W-1:0] stat_data;

    assign sda_line = sda_drv & ~sda_oe;

    i2c_slave_addr_unit #(.SYNC_STAGES(3)) i_i2c_slave_addr_unit (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_drv), .sda_in(sda_line),
        .cfg_ten_bit(cfg_ten_bit), .cfg_gc_en(cfg_gc_en), .cfg_addr(cfg_addr),
        .stat_rd(stat_rd), .sda_oe(sda_oe), .stat_data(stat_data)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // behavioural reference model state
    bit e_sel, e_alt, e_sb, e_rd, e_sr, e_srk, e_nak;
    bit m_armed;
    int m_ph;          // 0 idle, 1 first byte, 2 second byte, 3 data, 4 ignoring
    bit seen_sr;

    function automatic logic [7:0] exp_stat();
        return {1'b0, e_nak, e_srk, e_sr, e_rd, e_sb, e_alt, e_sel};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic hold(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_stat(input string req);
        chk(req, stat_data, exp_stat());
    endtask

    task automatic read_stat(input string req);
        @(negedge clk);
        stat_rd = 1'b1;
        chk(req, stat_data, exp_stat());
        @(negedge clk);
        stat_rd = 1'b0;
        e_sr = 0; e_nak = 0;
        chk(req, stat_data, exp_stat());
    endtask

    task automatic put_bit(input logic b, output logic r);
        sda_drv = b;   hold(HALF/2);
        scl_drv = 1'b1; hold(HALF/2);
        r = sda_line;  hold(HALF/2);
        scl_drv = 1'b0; hold(HALF/2);
    endtask

    task automatic t_start();
        if (e_sel) begin e_sr = 1; e_srk = 1; end
        e_sel = 0; m_ph = 1;
        sda_drv = 1'b1; hold(HALF/2);
        scl_drv = 1'b1; hold(HALF);
        sda_drv = 1'b0; hold(HALF);
        scl_drv = 1'b0; hold(HALF/2);
    endtask

    task automatic t_stop();
        if (e_sel) begin e_sr = 1; e_srk = 0; end
        e_sel = 0; m_armed = 0; m_ph = 0;
        sda_drv = 1'b0; hold(HALF/2);
        scl_drv = 1'b1; hold(HALF);
        sda_drv = 1'b1; hold(HALF);
    endtask

    function automatic int first_code(input logic [7:0] b);
        if (!cfg_ten_bit) begin
            if (b[7:1] == cfg_addr[6:0]) return 1;
        end else if (b[7:3] == 5'b11110 && b[2:1] == cfg_addr[9:8]) begin
            if (!b[0]) return 2;
            if (m_armed) return 3;
            return 0;
        end
        if (cfg_gc_en && b == 8'h00) return 4;
        if (cfg_gc_en && b == 8'h01) return 5;
        return 0;
    endfunction

    task automatic hit(input bit alt, input bit sb, input bit rd);
        e_sel = 1; e_alt = alt; e_sb = sb; e_rd = rd; m_ph = 3;
    endtask

    task automatic t_byte(input string req, input logic [7:0] b, input logic ackdrv);
        logic r;
        bit exp_ack;
        int code;
        exp_ack = 0;
        code = 0;
        if (m_ph == 1) begin
            code = first_code(b);
            exp_ack = (code != 0);
        end else if (m_ph == 2) begin
            exp_ack = (b == cfg_addr[7:0]);
        end
        for (int i = 7; i >= 0; i--) put_bit(b[i], r);
        put_bit(ackdrv, r);
        chk(req, r, exp_ack ? 1'b0 : ackdrv);
        if (m_ph == 1) begin
            case (code)
                1: hit(0, 0, b[0]);
                2: begin m_armed = 0; m_ph = 2; end
                3: hit(0, 0, 1);
                4: hit(1, 0, 0);
                5: hit(1, 1, 1);
                default: begin m_armed = 0; m_ph = 4; end
            endcase
        end else if (m_ph == 2) begin
            if (exp_ack) begin hit(0, 0, 0); m_armed = 1; end
            else begin m_armed = 0; m_ph = 4; end
        end else if (m_ph == 3) begin
            if (ackdrv && e_sel) e_nak = 1;
        end
    endtask

    always @(negedge clk) begin
        if (stat_rd && stat_data[ST_SR]) seen_sr = 1;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 0; scl_drv = 1; sda_drv = 1; stat_rd = 0;
        cfg_ten_bit = 0; cfg_gc_en = 0; cfg_addr = 10'h05A;
        hold(5);
        rst_n = 1;
        hold(4);
        chk("reset status", stat_data, 8'h00);
        chk("reset sda", sda_line, 1'b1);

        // 7-bit write, data bytes, closing
        t_start();
        t_byte("R1 own write ack", 8'hB4, 1'b1);
        check_stat("R1 R5 selected write");
        t_byte("R8 data acked", 8'h3C, 1'b0);
        check_stat("R8 no nak");
        t_byte("R8 data refused", 8'hFF, 1'b1);
        check_stat("R8 nak set");
        t_stop();
        check_stat("R7 stop flag");
        read_stat("R9 read clears");

        // mismatch then bytes ignored
        t_start();
        t_byte("R6 mismatch released", 8'h66, 1'b1);
        t_byte("R6 later byte ignored", 8'hB4, 1'b1);
        check_stat("R6 status unchanged");
        t_stop();
        check_stat("R7 no flag when idle");

        // 7-bit read, repeated opening
        t_start();
        t_byte("R1 own read ack", 8'hB5, 1'b1);
        check_stat("R1 read direction");
        t_start();
        check_stat("R7 restart flag");
        t_byte("R1 write after restart", 8'hB4, 1'b1);
        t_stop();
        check_stat("R7 stop kind");
        read_stat("R9 read clears again");

        // reserved addresses
        t_start();
        t_byte("R4 general call disabled", 8'h00, 1'b1);
        t_stop();
        cfg_gc_en = 1;
        t_start();
        t_byte("R4 general call ack", 8'h00, 1'b1);
        check_stat("R4 general call status");
        t_start();
        t_byte("R4 start byte ack", 8'h01, 1'b1);
        check_stat("R4 start byte status");
        t_stop();
        read_stat("R9 read after reserved");

        // 10-bit
        cfg_ten_bit = 1; cfg_gc_en = 0; cfg_addr = 10'h2A7;
        t_start();
        t_byte("R2 header ack", 8'hF4, 1'b1);
        check_stat("R2 header not selected");
        t_byte("R2 low byte ack", 8'hA7, 1'b1);
        check_stat("R2 selected");
        t_start();
        t_byte("R3 read header ack", 8'hF5, 1'b1);
        check_stat("R3 read selected");
        t_stop();
        read_stat("R9 after 10-bit");
        t_start();
        t_byte("R3 unarmed read refused", 8'hF5, 1'b1);
        t_stop();
        t_start();
        t_byte("R2 header ack again", 8'hF4, 1'b1);
        t_byte("R2 wrong low byte", 8'h12, 1'b1);
        check_stat("R2 not selected");
        t_stop();
        check_stat("R7 no flag after refused");

        // flag event meeting a read in the same cycle
        cfg_ten_bit = 0; cfg_addr = 10'h05A;
        t_start();
        t_byte("R10 select", 8'hB4, 1'b1);
        seen_sr = 0;
        @(negedge clk);
        stat_rd = 1'b1;
        t_stop();
        hold(2);
        stat_rd = 1'b0;
        e_sr = 0; e_nak = 0;
        chk("R10 event kept over clear", seen_sr, 1'b1);
        check_stat("R9 cleared after held read");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule